// File: doc/BRIEF.md
# NAND Command Cycle Sequencer

This block carries out one NAND flash operation at a time. Register-style inputs supply the operation: a command word with the two command bytes and the address-cycle count, a low and a high address word, and an operation mask. Writing the mask is the start strobe. Each mask bit stands for a fixed bus pattern. The pattern is made of these steps, in this order:

- a first command byte;
- zero to five address bytes;
- a second command byte, sent either before the data phase or after it as a confirm;
- a wait on the selected ready/busy line;
- a data phase handed to an external packet port.

All bus cycles use fixed, parameterized setup, strobe and hold lengths. The status operation is a special case. It sends its command and then performs one read strobe. The byte returned on that strobe goes to a dedicated flash-status output, not to the data port.

A host sets up the fields, pulses the start strobe and then watches `busy` and `done`. It polls the ready status bits and, for operations with data, serves the `data_go`/`data_end` handshake. Starts that arrive while an operation runs are refused and flagged. A wait on ready/busy that lasts too long ends the operation with a timeout flag instead of `done`.

Top module: `nseq_top`

## Requirements
- R1: After reset `busy`, `done`, `cle`, `ale`, `data_go`, `busy_err` and `tmo_err` are 0. `we_n`, `re_n` and every `ce_n` bit are 1, and `flash_sts` is 0.
- R2: A `prog_wr` pulse in idle starts an operation only if two conditions hold. First, `prog_bits` must have at least one operation bit set. The operation bits are 0 page read, 2 erase, 3 status, 4 program, 6 read ID, 7 parameter read, 8 reset, 9 get feature and 10 set feature. Second, the target field `addr_hi[31:30]` must name an existing target (0 or 1). When several operation bits are set, the lowest one wins. A write that sets only bits 1 or 5, or that names target 2 or 3, has no effect.
- R3: A command cycle holds `cle`=1 and `ale`=0, drives the byte on `io_out` with `io_oe`=1, and pulses `we_n` low for T_WP clocks. The first command is `cmd_word[7:0]` and the second is `cmd_word[15:8]`.
- R4: An address cycle has the same timing as a command cycle but with `ale`=1 and `cle`=0. The count is `cmd_word[30:28]`, clamped to 5. The bytes are sent in this order: `addr_lo` from the least significant byte up, then `addr_hi[7:0]`.
- R5: The patterns are fixed per operation:
  - page read: command 1, address, command 2, wait, data in;
  - erase: command 1, address, command 2, wait;
  - program: command 1, address, data out, command 2;
  - read ID and set feature: command 1, address, data (in for read ID, out for set feature), with no wait;
  - parameter read and get feature: command 1, address, wait, data in;
  - reset: command 1, wait.
- R6: While `busy` is high, only `ce_n[target]` is low. When idle, all `ce_n` bits are high.
- R7: `ready_sts` copies `rb_n` one clock later, with 1 meaning ready. A wait step moves on only once the selected target's bit is 1.
- R8: If the selected line stays not-ready for `tmo_limit` clocks during a wait, the operation ends without `done` and sets the sticky `tmo_err`.
- R9: A status operation sends only its first command and then one read cycle, with `re_n` low and `io_oe`=0. The byte on `io_in` at that cycle appears on `flash_sts`. No address cycles are sent, whatever the count field says.
- R10: During the data phase `data_go`=1 and `data_dir` is 1 for data in and 0 for data out. The phase ends on `data_end`.
- R11: `done` is a one-clock pulse at the end of a completed operation. `busy` is low on the clock after it.
- R12: A valid start strobe while `busy` is high, including the cycle in which `done` is high, is ignored and sets `busy_err`. `busy_err` and `tmo_err` clear on the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_wr | input | 1 | Start strobe (operation mask write) |
| prog_bits | input | 11 | Operation mask |
| cmd_word | input | 32 | Command bytes and address-cycle count |
| addr_lo | input | 32 | Address bytes 0 to 3 |
| addr_hi | input | 32 | Address byte 4 in [7:0], target in [31:30] |
| tmo_limit | input | TW | Ready-wait timeout in clocks (1 or more) |
| rb_n | input | NT | Ready/busy lines, 1 = ready |
| io_in | input | 8 | Flash data bus input |
| data_end | input | 1 | Data phase finished |
| io_out | output | 8 | Flash data bus output |
| io_oe | output | 1 | Output enable for io_out |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| ce_n | output | NT | Chip enables, active low |
| data_go | output | 1 | Data phase request |
| data_dir | output | 1 | 1 = data in, 0 = data out |
| ready_sts | output | NT | Registered ready/busy status |
| flash_sts | output | 8 | Captured status byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| busy_err | output | 1 | Sticky refused-start flag |
| tmo_err | output | 1 | Sticky ready-wait timeout flag |

## Verification
The delicate overlap is a start strobe that arrives in the same clock as the `done` pulse of the previous operation. At that point the sequencer is still finishing, so the strobe must be refused and flagged. It must not be taken as a new operation. The bench provokes this by raising `prog_wr` on the half-cycle where it first sees `done`. It then expects `busy_err` set, `busy` low and no new bus cycles logged. A second overlap is a start strobe that lands in the middle of a ready wait. The bench checks that the running pattern finishes unchanged.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

   typedef enum logic [1:0] {BK_CMD, BK_ADDR, BK_RD} bus_kind_t;

   typedef enum logic [3:0] {
      S_IDLE, S_CMD1, S_ADDR, S_CMD2E, S_WAIT, S_DATA, S_CMD2L, S_STAT, S_FIN
   } seq_st_t;

   // step flags of one fixed bus pattern
   typedef struct packed {
      logic has_addr;
      logic cmd2_early;
      logic has_wait;
      logic has_data;
      logic data_in;
      logic cmd2_late;
      logic is_stat;
   } pat_t;

   localparam int OP_BITS = 11;
   // operation bits that start something; 1 and 5 are reserved
   localparam logic [OP_BITS-1:0] OP_VALID = 11'b111_1101_1101;

   function automatic pat_t op_pattern(input logic [3:0] idx);
      pat_t p;
      p = '0;
      case (idx)
         4'd0:  p = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}; // page read
         4'd2:  p = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}; // erase
         4'd3:  p = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}; // status
         4'd4:  p = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}; // program
         4'd6:  p = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}; // read id
         4'd7:  p = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}; // param read
         4'd8:  p = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}; // reset
         4'd9:  p = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}; // get feature
         4'd10: p = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}; // set feature
         default: p = '0;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/nseq_decode.sv
module nseq_decode
   import nseq_pkg::*;
#(
   parameter int PW = OP_BITS
) (
   input  logic [PW-1:0] prog_bits,
   output logic          valid,
   output pat_t          pat
);
   generate
      if (PW != OP_BITS) begin : g_bad_pw
         $error("nseq_decode: PW must equal OP_BITS");
      end
   endgenerate

   logic [PW-1:0] masked;
   logic [3:0]    idx;

   assign masked = prog_bits & OP_VALID;
   assign valid  = |masked;

   // lowest set operation bit wins
   always_comb begin
      idx = 4'd0;
      for (int i = PW - 1; i >= 0; i--) begin
         if (masked[i]) idx = 4'(i);
      end
   end

   assign pat = op_pattern(idx);
endmodule

// File: rtl/nseq_bus.sv
module nseq_bus
   import nseq_pkg::*;
#(
   parameter int T_SU = 2,
   parameter int T_WP = 3,
   parameter int T_HD = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      go,
   input  bus_kind_t kind,
   input  logic [7:0] byte_in,
   input  logic [7:0] io_in,
   output logic      fin,
   output logic      cle,
   output logic      ale,
   output logic      we_n,
   output logic      re_n,
   output logic [7:0] io_out,
   output logic      io_oe,
   output logic [7:0] rd_byte
);
   localparam int LEN = T_SU + T_WP + T_HD;
   localparam int CW  = $clog2(LEN + 1);
   localparam logic [CW-1:0] C_SU   = CW'(T_SU);
   localparam logic [CW-1:0] C_PEND = CW'(T_SU + T_WP);
   localparam logic [CW-1:0] C_LAST = CW'(LEN - 1);
   localparam logic [CW-1:0] C_SAMP = CW'(T_SU + T_WP - 1);

   generate
      if (T_SU < 1 || T_WP < 1 || T_HD < 1) begin : g_bad_timing
         $error("nseq_bus: each phase needs at least one clock");
      end
   endgenerate

   logic          act;
   logic [CW-1:0] cnt;
   bus_kind_t     kq;
   logic [7:0]    bq;
   logic          in_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act     <= 1'b0;
         cnt     <= '0;
         kq      <= BK_CMD;
         bq      <= '0;
         rd_byte <= '0;
      end else if (!act) begin
         if (go) begin
            act <= 1'b1;
            cnt <= '0;
            kq  <= kind;
            bq  <= byte_in;
         end
      end else begin
         if (kq == BK_RD && cnt == C_SAMP) rd_byte <= io_in;
         if (cnt == C_LAST) act <= 1'b0;
         else               cnt <= cnt + 1'b1;
      end
   end

   assign in_pulse = act && (cnt >= C_SU) && (cnt < C_PEND);
   assign cle      = act && (kq == BK_CMD);
   assign ale      = act && (kq == BK_ADDR);
   assign we_n     = !(in_pulse && kq != BK_RD);
   assign re_n     = !(in_pulse && kq == BK_RD);
   assign io_oe    = act && (kq != BK_RD);
   assign io_out   = act ? bq : 8'h00;
   assign fin      = act && (cnt == C_LAST);

   assert_latch_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));
   assert_we_needs_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |-> (cle || ale));
   assert_byte_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !fin) |=> $stable(io_out));
   assert_read_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(re_n) |-> !io_oe);
endmodule

// File: rtl/nseq_rbwait.sv
module nseq_rbwait #(
   parameter int NT = 2,
   parameter int TW = 16,
   localparam int SW = (NT > 1) ? $clog2(NT) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NT-1:0] rb_n,
   input  logic [SW-1:0] sel,
   input  logic          arm,
   input  logic [TW-1:0] limit,
   output logic [NT-1:0] rdy_sts,
   output logic          ok,
   output logic          tmo
);
   logic [TW-1:0] cnt;
   logic          rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_sts <= '1;
         cnt     <= '0;
      end else begin
         rdy_sts <= rb_n;
         if (!arm)     cnt <= '0;
         else if (!rdy) cnt <= cnt + 1'b1;
      end
   end

   assign rdy = rdy_sts[sel];
   assign ok  = arm && rdy;
   assign tmo = arm && !rdy && (cnt == limit - TW'(1));

   assert_sts_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (rdy_sts == $past(rb_n)));
   assert_no_ok_and_tmo_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ok && tmo));
endmodule

// File: rtl/nseq_top.sv
module nseq_top
   import nseq_pkg::*;
#(
   parameter int NT   = 2,
   parameter int TW   = 16,
   parameter int T_SU = 2,
   parameter int T_WP = 3,
   parameter int T_HD = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          prog_wr,
   input  logic [10:0]   prog_bits,
   input  logic [31:0]   cmd_word,
   input  logic [31:0]   addr_lo,
   input  logic [31:0]   addr_hi,
   input  logic [TW-1:0] tmo_limit,
   input  logic [NT-1:0] rb_n,
   input  logic [7:0]    io_in,
   input  logic          data_end,
   output logic [7:0]    io_out,
   output logic          io_oe,
   output logic          cle,
   output logic          ale,
   output logic          we_n,
   output logic          re_n,
   output logic [NT-1:0] ce_n,
   output logic          data_go,
   output logic          data_dir,
   output logic [NT-1:0] ready_sts,
   output logic [7:0]    flash_sts,
   output logic          busy,
   output logic          done,
   output logic          busy_err,
   output logic          tmo_err
);
   localparam int SW = (NT > 1) ? $clog2(NT) : 1;
   localparam logic [2:0] NT_L    = 3'(NT);
   localparam logic [2:0] MAX_ADR = 3'd5;

   generate
      if (NT < 1 || NT > 4) begin : g_bad_nt
         $error("nseq_top: NT must be 1 to 4");
      end
      if (TW < 2) begin : g_bad_tw
         $error("nseq_top: TW must be at least 2");
      end
   endgenerate

   seq_st_t     state;
   pat_t        pat_q, dec_pat;
   logic        dec_valid;
   logic [7:0]  cmd1_q, cmd2_q;
   logic [2:0]  nadr_q, aidx, nadr_in;
   logic [39:0] abytes_q;
   logic [1:0]  cs_q;
   logic        issued;
   logic        start_ok, start_req;

   // bus unit interface
   logic       bus_go, bus_fin;
   bus_kind_t  bus_kind;
   logic [7:0] bus_byte, rd_byte;
   logic       bus_state;
   logic       wt_ok, wt_tmo;

   nseq_decode u_dec (
      .prog_bits (prog_bits),
      .valid     (dec_valid),
      .pat       (dec_pat)
   );

   assign start_req = prog_wr && dec_valid;
   assign start_ok  = start_req && (state == S_IDLE) && ({1'b0, addr_hi[31:30]} < NT_L);
   assign nadr_in   = (cmd_word[30:28] > MAX_ADR) ? MAX_ADR : cmd_word[30:28];

   // successor of each step, following the pattern flags
   seq_st_t nx_data, nx_wait, nx_c2, nx_addr, nx_c1;
   assign nx_data = pat_q.cmd2_late  ? S_CMD2L : S_FIN;
   assign nx_wait = pat_q.has_data   ? S_DATA  : nx_data;
   assign nx_c2   = pat_q.has_wait   ? S_WAIT  : nx_wait;
   assign nx_addr = pat_q.cmd2_early ? S_CMD2E : nx_c2;
   assign nx_c1   = pat_q.is_stat ? S_STAT :
                    (pat_q.has_addr && nadr_q != 3'd0) ? S_ADDR : nx_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         pat_q     <= '0;
         cmd1_q    <= '0;
         cmd2_q    <= '0;
         nadr_q    <= '0;
         aidx      <= '0;
         abytes_q  <= '0;
         cs_q      <= '0;
         issued    <= 1'b0;
         flash_sts <= '0;
         busy_err  <= 1'b0;
         tmo_err   <= 1'b0;
      end else begin
         if (bus_go) issued <= 1'b1;
         if (start_req && state != S_IDLE) busy_err <= 1'b1;
         case (state)
            S_IDLE: if (start_ok) begin
               state    <= S_CMD1;
               pat_q    <= dec_pat;
               cmd1_q   <= cmd_word[7:0];
               cmd2_q   <= cmd_word[15:8];
               nadr_q   <= nadr_in;
               abytes_q <= {addr_hi[7:0], addr_lo};
               cs_q     <= addr_hi[31:30];
               aidx     <= '0;
               issued   <= 1'b0;
               busy_err <= 1'b0;
               tmo_err  <= 1'b0;
            end
            S_CMD1: if (bus_fin) begin
               state  <= nx_c1;
               issued <= 1'b0;
            end
            S_ADDR: if (bus_fin) begin
               issued <= 1'b0;
               if (aidx == nadr_q - 3'd1) begin
                  aidx  <= '0;
                  state <= nx_addr;
               end else begin
                  aidx <= aidx + 3'd1;
               end
            end
            S_CMD2E: if (bus_fin) begin
               state  <= nx_c2;
               issued <= 1'b0;
            end
            S_WAIT: begin
               if (wt_ok)       state <= nx_wait;
               else if (wt_tmo) begin
                  state   <= S_IDLE;
                  tmo_err <= 1'b1;
               end
            end
            S_DATA: if (data_end) state <= nx_data;
            S_CMD2L: if (bus_fin) begin
               state  <= S_FIN;
               issued <= 1'b0;
            end
            S_STAT: if (bus_fin) begin
               state     <= S_FIN;
               issued    <= 1'b0;
               flash_sts <= rd_byte;
            end
            S_FIN:   state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign bus_state = (state == S_CMD1) || (state == S_ADDR) || (state == S_CMD2E) ||
                      (state == S_CMD2L) || (state == S_STAT);
   assign bus_go    = bus_state && !issued;
   assign bus_kind  = (state == S_STAT) ? BK_RD : (state == S_ADDR) ? BK_ADDR : BK_CMD;
   assign bus_byte  = (state == S_CMD1) ? cmd1_q :
                      (state == S_ADDR) ? abytes_q[{aidx, 3'b000} +: 8] : cmd2_q;

   nseq_bus #(.T_SU(T_SU), .T_WP(T_WP), .T_HD(T_HD)) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (bus_go),
      .kind    (bus_kind),
      .byte_in (bus_byte),
      .io_in   (io_in),
      .fin     (bus_fin),
      .cle     (cle),
      .ale     (ale),
      .we_n    (we_n),
      .re_n    (re_n),
      .io_out  (io_out),
      .io_oe   (io_oe),
      .rd_byte (rd_byte)
   );

   nseq_rbwait #(.NT(NT), .TW(TW)) u_rb (
      .clk     (clk),
      .rst_n   (rst_n),
      .rb_n    (rb_n),
      .sel     (cs_q[SW-1:0]),
      .arm     (state == S_WAIT),
      .limit   (tmo_limit),
      .rdy_sts (ready_sts),
      .ok      (wt_ok),
      .tmo     (wt_tmo)
   );

   assign busy     = (state != S_IDLE);
   assign done     = (state == S_FIN);
   assign data_go  = (state == S_DATA);
   assign data_dir = pat_q.data_in;

   for (genvar g = 0; g < NT; g++) begin : g_ce
      assign ce_n[g] = !(busy && cs_q == 2'(g));
   end

   assert_pulse_then_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   assert_single_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~ce_n) <= 1);
   assert_idle_no_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (&ce_n));
   assert_refuse_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && busy) |=> busy_err);
   assert_tmo_from_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_err) |-> $past(state == S_WAIT));
   assert_data_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (data_go && !data_end) |=> data_go);
endmodule

// File: tb/nseq_top_bench.sv
module nseq_top_bench;
   localparam int NT = 2;
   localparam int TW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic prog_wr = 1'b0;
   logic [10:0] prog_bits = '0;
   logic [31:0] cmd_word = '0, addr_lo = '0, addr_hi = '0;
   logic [TW-1:0] tmo_limit = 16'd1000;
   logic [NT-1:0] rb_n;
   logic [7:0] io_in;
   logic data_end = 1'b0;
   logic [7:0] io_out;
   logic io_oe, cle, ale, we_n, re_n, data_go, data_dir, busy, done, busy_err, tmo_err;
   logic [NT-1:0] ce_n, ready_sts;
   logic [7:0] flash_sts;

   int n_chk = 0, n_err = 0;
   int cyc = 0;
   int rb_until = 0;
   int rb_tgt = 0;
   logic [7:0] stat_val = 8'h00;

   int ev_k [0:255];
   int ev_b [0:255];
   int n_ev = 0;
   int done_cnt = 0;
   logic pwe = 1'b1, pre = 1'b1, pdg = 1'b0;
   int dcnt = 0;

   always #4 clk = ~clk; // 125 MHz

   nseq_top #(.NT(NT), .TW(TW)) u_nseq_top (
      .clk(clk), .rst_n(rst_n), .prog_wr(prog_wr), .prog_bits(prog_bits),
      .cmd_word(cmd_word), .addr_lo(addr_lo), .addr_hi(addr_hi),
      .tmo_limit(tmo_limit), .rb_n(rb_n), .io_in(io_in), .data_end(data_end),
      .io_out(io_out), .io_oe(io_oe), .cle(cle), .ale(ale), .we_n(we_n),
      .re_n(re_n), .ce_n(ce_n), .data_go(data_go), .data_dir(data_dir),
      .ready_sts(ready_sts), .flash_sts(flash_sts), .busy(busy), .done(done),
      .busy_err(busy_err), .tmo_err(tmo_err)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always_comb begin
      for (int t = 0; t < NT; t++) rb_n[t] = !(t == rb_tgt && cyc < rb_until);
      io_in = re_n ? 8'h00 : stat_val;
   end

   // bus monitor: 1 cmd, 2 addr, 3 data phase (byte = dir), 4 read strobe
   always @(negedge clk) begin
      if (!pwe && we_n) begin
         ev_k[n_ev & 255] <= cle ? 1 : (ale ? 2 : 0);
         ev_b[n_ev & 255] <= int'(io_out);
         n_ev <= n_ev + 1;
      end else if (!pre && re_n) begin
         ev_k[n_ev & 255] <= 4;
         ev_b[n_ev & 255] <= 0;
         n_ev <= n_ev + 1;
      end else if (data_go && !pdg) begin
         ev_k[n_ev & 255] <= 3;
         ev_b[n_ev & 255] <= int'(data_dir);
         n_ev <= n_ev + 1;
      end
      if (done) done_cnt <= done_cnt + 1;
      pwe <= we_n;
      pre <= re_n;
      pdg <= data_go;
   end

   // data port responder
   always @(negedge clk) begin
      data_end <= 1'b0;
      if (data_go && !data_end) begin
         if (dcnt == 3) begin
            data_end <= 1'b1;
            dcnt <= 0;
         end else dcnt <= dcnt + 1;
      end
   end

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_ev(input int base, input int i, input int k, input int b, input string tag);
      chk(ev_k[(base + i) & 255] == k && ev_b[(base + i) & 255] == b, tag,
          ev_k[(base + i) & 255] * 256 + ev_b[(base + i) & 255], k * 256 + b);
   endtask

   task automatic launch(input logic [10:0] p, input logic [31:0] cw,
                         input logic [31:0] lo, input logic [31:0] hi,
                         input int hold, input int tgt);
      @(negedge clk);
      prog_bits = p; cmd_word = cw; addr_lo = lo; addr_hi = hi;
      rb_tgt = tgt; rb_until = cyc + hold;
      prog_wr = 1'b1;
      @(negedge clk);
      prog_wr = 1'b0;
   endtask

   task automatic wait_idle(output int took);
      took = 1;
      while (busy && took < 20000) begin
         @(negedge clk);
         took++;
      end
   endtask

   task automatic t_reset;
      chk(!busy && !done && !cle && !ale && !data_go && !busy_err && !tmo_err,
          "R1 control outputs", {busy, done, cle, ale, data_go, busy_err, tmo_err}, 0);
      chk(we_n && re_n && ce_n == 2'b11, "R1 strobes", {we_n, re_n, ce_n}, 4'hF);
      chk(flash_sts == 8'h00, "R1 flash_sts", flash_sts, 0);
   endtask

   task automatic t_erase;
      int b, d0, took;
      b = n_ev; d0 = done_cnt;
      launch(11'h004, 32'h3000_D060, 32'h0033_2211, 32'h0, 100, 0);
      chk(ce_n == 2'b10, "R6 target 0 enabled", ce_n, 2);
      wait_idle(took);
      @(negedge clk);
      chk(n_ev - b == 5, "R5 erase cycle count", n_ev - b, 5);
      chk_ev(b, 0, 1, 8'h60, "R3 erase first command");
      chk_ev(b, 1, 2, 8'h11, "R4 address byte 0");
      chk_ev(b, 2, 2, 8'h22, "R4 address byte 1");
      chk_ev(b, 3, 2, 8'h33, "R4 address byte 2");
      chk_ev(b, 4, 1, 8'hD0, "R3 erase second command");
      chk(took >= 98, "R7 erase waits for ready", took, 98);
      chk(done_cnt - d0 == 1, "R11 one done pulse", done_cnt - d0, 1);
   endtask

   task automatic t_page_read;
      int b, took;
      b = n_ev;
      launch(11'h001, 32'h5000_3000, 32'h0403_0201, 32'h0000_0005, 150, 0);
      wait_idle(took);
      @(negedge clk);
      chk(n_ev - b == 8, "R5 page read cycle count", n_ev - b, 8);
      for (int i = 0; i < 5; i++) chk_ev(b, 1 + i, 2, i + 1, "R4 five byte order");
      chk_ev(b, 6, 1, 8'h30, "R5 page read command 2 before data");
      chk_ev(b, 7, 3, 1, "R10 data in phase");
      chk(took >= 148, "R7 page read waits", took, 148);
   endtask

   task automatic t_program;
      int b, took;
      b = n_ev;
      launch(11'h010, 32'h2000_1080, 32'h0000_BBAA, 32'h0, 0, 0);
      wait_idle(took);
      @(negedge clk);
      chk(n_ev - b == 5, "R5 program cycle count", n_ev - b, 5);
      chk_ev(b, 2, 2, 8'hBB, "R4 program second address");
      chk_ev(b, 3, 3, 0, "R10 data out phase");
      chk_ev(b, 4, 1, 8'h10, "R5 confirm command after data");
   endtask

   task automatic t_set_feature;
      int b, took;
      b = n_ev;
      launch(11'h400, 32'h1000_00EF, 32'h0000_0089, 32'h0, 100, 0);
      wait_idle(took);
      @(negedge clk);
      chk(n_ev - b == 3, "R5 set feature cycle count", n_ev - b, 3);
      chk_ev(b, 2, 3, 0, "R10 set feature data out");
      chk(took < 90, "R5 set feature has no wait", took, 90);
   endtask

   task automatic t_status;
      int b, d0, took;
      b = n_ev; d0 = done_cnt;
      stat_val = 8'hA5;
      launch(11'h008, 32'h3000_0070, 32'h1234_5678, 32'h0, 0, 0);
      wait_idle(took);
      @(negedge clk);
      chk(n_ev - b == 2, "R9 status cycle count (no address)", n_ev - b, 2);
      chk_ev(b, 0, 1, 8'h70, "R9 status command");
      chk_ev(b, 1, 4, 0, "R9 one read strobe");
      chk(flash_sts == 8'hA5, "R9 flash_sts captured", flash_sts, 8'hA5);
      chk(done_cnt - d0 == 1, "R11 status done", done_cnt - d0, 1);
   endtask

   task automatic t_target1;
      int b, took;
      b = n_ev;
      launch(11'h100, 32'h0000_00FF, 32'h0, 32'h4000_0000, 60, 1);
      repeat (3) @(negedge clk);
      chk(ce_n == 2'b01, "R6 target 1 enabled", ce_n, 1);
      wait_idle(took);
      @(negedge clk);
      chk(n_ev - b == 1, "R5 reset single command", n_ev - b, 1);
      chk(took >= 56, "R7 wait uses selected target", took, 56);
   endtask

   task automatic t_drop;
      int b;
      b = n_ev;
      launch(11'h022, 32'h0000_0060, 32'h0, 32'h0, 0, 0);
      chk(!busy && ce_n == 2'b11, "R2 reserved bits ignored", busy, 0);
      launch(11'h100, 32'h0000_00FF, 32'h0, 32'h8000_0000, 0, 0);
      chk(!busy && ce_n == 2'b11, "R2 target 2 ignored", busy, 0);
      repeat (10) @(negedge clk);
      chk(n_ev == b, "R2 no bus cycles", n_ev - b, 0);
   endtask

   task automatic t_priority;
      int b, took;
      b = n_ev;
      launch(11'h00C, 32'h1000_D060, 32'h0000_0077, 32'h0, 0, 0);
      wait_idle(took);
      @(negedge clk);
      chk(n_ev - b == 3, "R2 lowest bit wins (erase)", n_ev - b, 3);
      chk_ev(b, 1, 2, 8'h77, "R2 erase address sent");
   endtask

   task automatic t_clamp;
      int b, took;
      b = n_ev;
      launch(11'h040, 32'h7000_0090, 32'h4433_2211, 32'h0000_0055, 0, 0);
      wait_idle(took);
      @(negedge clk);
      chk(n_ev - b == 7, "R4 count clamped to five", n_ev - b, 7);
      chk_ev(b, 5, 2, 8'h55, "R4 fifth byte from high word");
   endtask

   task automatic t_busy_err;
      int b, took;
      b = n_ev;
      launch(11'h100, 32'h0000_00FF, 32'h0, 32'h0, 80, 0);
      repeat (10) @(negedge clk);
      prog_bits = 11'h004; prog_wr = 1'b1;
      @(negedge clk);
      prog_wr = 1'b0;
      chk(busy_err, "R12 refused start flagged", busy_err, 1);
      wait_idle(took);
      @(negedge clk);
      chk(n_ev - b == 1, "R12 running pattern unchanged", n_ev - b, 1);
      launch(11'h008, 32'h0000_0070, 32'h0, 32'h0, 0, 0);
      chk(!busy_err, "R12 flag cleared by next start", busy_err, 0);
      wait_idle(took);
   endtask

   task automatic t_done_collide;
      int b, guard;
      launch(11'h008, 32'h0000_0070, 32'h0, 32'h0, 0, 0);
      guard = 0;
      while (!done && guard < 500) begin
         @(negedge clk);
         guard++;
      end
      b = n_ev;
      prog_bits = 11'h100; cmd_word = 32'h0000_00FF; prog_wr = 1'b1;
      @(negedge clk);
      prog_wr = 1'b0;
      chk(busy_err, "R12 start in done cycle refused", busy_err, 1);
      chk(!busy, "R11 idle after done", busy, 0);
      repeat (12) @(negedge clk);
      chk(n_ev == b, "R12 no cycles after collision", n_ev - b, 0);
   endtask

   task automatic t_timeout;
      int b, d0, took;
      b = n_ev; d0 = done_cnt;
      tmo_limit = 16'd20;
      launch(11'h004, 32'h1000_D060, 32'h0000_0001, 32'h0, 5000, 0);
      wait_idle(took);
      @(negedge clk);
      chk(tmo_err, "R8 timeout flag", tmo_err, 1);
      chk(done_cnt == d0, "R8 no done on timeout", done_cnt - d0, 0);
      chk(took < 100, "R8 abort in time", took, 100);
      chk(n_ev - b == 3, "R8 commands sent before wait", n_ev - b, 3);
      rb_until = 0;
      tmo_limit = 16'd1000;
   endtask

   task automatic t_ready_sts;
      @(negedge clk);
      rb_tgt = 0; rb_until = cyc + 6;
      @(negedge clk);
      chk(ready_sts == 2'b10, "R7 status shows busy line", ready_sts, 2);
      repeat (8) @(negedge clk);
      chk(ready_sts == 2'b11, "R7 status shows ready", ready_sts, 3);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_erase();
      t_page_read();
      t_program();
      t_set_feature();
      t_status();
      t_target1();
      t_drop();
      t_priority();
      t_clamp();
      t_busy_err();
      t_done_collide();
      t_timeout();
      t_ready_sts();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule